// File: doc/BRIEF.md
# Boost Frequency Governor Datapath

This block turns the outcome of an activity monitor into a memory clock request. Each time the monitor raises an event, the caller pulses `start_i` together with one "sustained above" flag, one "sustained below" flag and the latest averaged activity count for every channel. The block then does three things for each channel:

- It grows or shrinks a boost frequency.
- It decides which sustained-breach detectors stay armed for the next interval.
- It places a pair of average watermarks around the new count.

One cycle later it reduces all channels to a single target frequency and pulses `done_o`.

In parallel, and independent of events, the block keeps a pair of raw watermarks per channel. These follow the current clock frequency and are reloaded whenever that input changes. All frequencies are in kHz. The sampling period is 12 ms, the boost step is 16000 kHz and the average band is 6 per mille of the maximum frequency per millisecond. All divisions truncate.

Top module: `boost_governor`

## Requirements
- R1: While reset is held and after it, every boost is 0, both arm outputs of every channel are 1, and `target_o`, `done_o` and every watermark are 0.
- R2: When `start_i` is high and a channel's above flag is set, the new boost becomes old×up_coeff/100 + 16000. If that value is greater than or equal to `max_freq_i`, the boost is clamped to `max_freq_i` and the above arm is cleared; otherwise the above arm is set. The below arm is set in both cases. The new boost and arms appear one clock after `start_i`.
- R3: When `start_i` is high, a channel's below flag is set and its above flag is clear, the new boost becomes old×dn_coeff/100 and the above arm is set. A result under 8000 becomes 0 and clears the below arm. A result of 8000 or more is kept and sets the below arm.
- R4: An event with neither flag set leaves that channel's boost and above arm unchanged.
- R5: For a channel with a nonzero `dep_thr_i`, this rule is applied last. An average at or above the threshold sets the below arm. Otherwise, if the new boost is 0, the below arm is cleared.
- R6: With band = (max_freq×6/1000)×12, each event sets `avg_hi_o` to avg+band and `avg_lo_o` to max(avg,band)−band, one clock after `start_i`.
- R7: One clock after `cur_freq_i` changes, `raw_hi_o` becomes cur×12×up_thr/100 and `raw_lo_o` becomes cur×12×dn_thr/100.
- R8: The channel target is (avg/12)×(10000/up_thr)/100 + boost. For a channel with a nonzero `dep_thr_i` and an average at or above it, the target is raised to `floor_freq_i` when that is larger. `target_o` is the largest channel target and is valid two clocks after `start_i`.
- R9: `done_o` is high for exactly one cycle, two clocks after a single `start_i` pulse.
- R10: When both flags of a channel are set, the above rule of R2 applies and the below flag is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle event strobe |
| up_evt_i | input | NCH | Sustained-above flag per channel |
| dn_evt_i | input | NCH | Sustained-below flag per channel |
| avg_cnt_i | input | NCH×CW | Averaged activity count per channel |
| cur_freq_i | input | FW | Current clock frequency, kHz |
| max_freq_i | input | FW | Highest reachable frequency, kHz |
| floor_freq_i | input | FW | Floor frequency for dependent channels, kHz |
| up_coeff_i | input | NCH×KW | Boost growth factor, percent |
| dn_coeff_i | input | NCH×KW | Boost decay factor, percent |
| up_thr_i | input | NCH×HW | Upper watermark threshold, percent, nonzero |
| dn_thr_i | input | NCH×HW | Lower watermark threshold, percent |
| dep_thr_i | input | NCH×CW | Dependency threshold, 0 disables |
| boost_o | output | NCH×FW | Boost frequency per channel |
| arm_above_o | output | NCH | Re-arm sustained-above detector |
| arm_below_o | output | NCH | Re-arm sustained-below detector |
| avg_hi_o | output | NCH×(CW+1) | Upper average watermark |
| avg_lo_o | output | NCH×CW | Lower average watermark |
| raw_hi_o | output | NCH×(FW+4) | Upper raw watermark |
| raw_lo_o | output | NCH×(FW+4) | Lower raw watermark |
| target_o | output | CW+8 | Overall target frequency, kHz |
| done_o | output | 1 | Target valid pulse |

## Verification
Boost, arms and average watermarks are due one clock after `start_i`. Target and `done_o` are due one clock after that, and `done_o` must be low again on the following clock. Raw watermarks are due one clock after a `cur_freq_i` change. The bench raises `start_i` on a falling edge and reads the first group of results on the next falling edge. It reads the target and the done pulse on the falling edge after that, and the cleared done on the one after. Each result is therefore sampled half a cycle after the edge that loads its register.

// File: rtl/bgov_pkg.sv
package bgov_pkg;
  localparam int unsigned STEP_KHZ      = 16000;
  localparam int unsigned SNAP_KHZ      = STEP_KHZ / 2;
  localparam int unsigned PERIOD_MS     = 12;
  localparam int unsigned BAND_PERMILLE = 6;
  localparam int unsigned PCT           = 100;
  localparam int unsigned PCT_SQ        = 10000;

  typedef struct packed {
    logic above;
    logic below;
  } arm_t;
endpackage

// File: rtl/bgov_boost_step.sv
module bgov_boost_step
  import bgov_pkg::*;
#(
  parameter int FW = 32,
  parameter int CW = 32,
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          up_evt,
  input  logic          dn_evt,
  input  logic [CW-1:0] avg_in,
  input  logic [FW-1:0] max_freq,
  input  logic [KW-1:0] up_coeff,
  input  logic [KW-1:0] dn_coeff,
  input  logic [CW-1:0] dep_thr,
  output logic [FW-1:0] boost_q,
  output arm_t          arm_q,
  output logic [CW-1:0] avg_q,
  output logic [CW:0]   avg_hi_q,
  output logic [CW-1:0] avg_lo_q
);
  localparam int PW = FW + KW;
  localparam int BW = FW + 4;

  logic [PW-1:0] grow, shrink;
  logic [BW-1:0] band;
  logic [FW-1:0] boost_n;
  arm_t          arm_n;
  logic [CW:0]   avg_hi_n;
  logic [CW-1:0] avg_lo_n;

  always_comb begin
    grow   = (PW'(boost_q) * PW'(up_coeff)) / PW'(PCT) + PW'(STEP_KHZ);
    shrink = (PW'(boost_q) * PW'(dn_coeff)) / PW'(PCT);
    band   = ((BW'(max_freq) * BW'(BAND_PERMILLE)) / BW'(1000)) * BW'(PERIOD_MS);

    boost_n = boost_q;
    arm_n   = arm_q;
    if (up_evt) begin
      arm_n.below = 1'b1;
      if (grow >= PW'(max_freq)) begin
        boost_n     = max_freq;
        arm_n.above = 1'b0;
      end else begin
        boost_n     = FW'(grow);
        arm_n.above = 1'b1;
      end
    end else if (dn_evt) begin
      arm_n.above = 1'b1;
      if (shrink < PW'(SNAP_KHZ)) begin
        boost_n     = '0;
        arm_n.below = 1'b0;
      end else begin
        boost_n     = FW'(shrink);
        arm_n.below = 1'b1;
      end
    end

    if (dep_thr != '0) begin
      if (avg_in >= dep_thr) arm_n.below = 1'b1;
      else if (boost_n == '0) arm_n.below = 1'b0;
    end

    avg_hi_n = (CW+1)'(avg_in) + (CW+1)'(band);
    avg_lo_n = (BW'(avg_in) >= band) ? CW'(BW'(avg_in) - band) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boost_q  <= '0;
      arm_q    <= '{above: 1'b1, below: 1'b1};
      avg_q    <= '0;
      avg_hi_q <= '0;
      avg_lo_q <= '0;
    end else if (start) begin
      boost_q  <= boost_n;
      arm_q    <= arm_n;
      avg_q    <= avg_in;
      avg_hi_q <= avg_hi_n;
      avg_lo_q <= avg_lo_n;
    end
  end

  // R2
  up_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && up_evt) |=> (boost_q <= $past(max_freq)));
  // R2
  up_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && up_evt && max_freq != '0) |=> arm_q.below);
  // R3
  dn_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !up_evt && dn_evt) |=> (boost_q == '0 || boost_q >= FW'(SNAP_KHZ)));
  // R3
  dn_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !up_evt && dn_evt) |=> arm_q.above);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !up_evt && !dn_evt) |=> (boost_q == $past(boost_q) && arm_q.above == $past(arm_q.above)));
  // R6
  avg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CW+1)'(avg_lo_q) <= avg_hi_q);
endmodule

// File: rtl/bgov_target.sv
module bgov_target
  import bgov_pkg::*;
#(
  parameter int FW = 32,
  parameter int CW = 32,
  parameter int HW = 8,
  parameter int TW = CW + 8
) (
  input  logic [CW-1:0] avg,
  input  logic [FW-1:0] boost,
  input  logic [HW-1:0] up_thr,
  input  logic [CW-1:0] dep_thr,
  input  logic [FW-1:0] floor_freq,
  output logic [TW-1:0] tgt
);
  localparam int MW = CW + 14;

  logic [CW-1:0] per;
  logic [13:0]   coef;
  logic [MW-1:0] scaled;
  logic [TW-1:0] sum;

  always_comb begin
    per    = avg / CW'(PERIOD_MS);
    coef   = (up_thr == '0) ? 14'(PCT_SQ) : 14'(14'(PCT_SQ) / 14'(up_thr));
    scaled = (MW'(per) * MW'(coef)) / MW'(PCT);
    sum    = TW'(scaled) + TW'(boost);
    tgt    = sum;
    if (dep_thr != '0 && avg >= dep_thr && TW'(floor_freq) > sum)
      tgt = TW'(floor_freq);
  end
endmodule

// File: rtl/bgov_raw_wmark.sv
module bgov_raw_wmark
  import bgov_pkg::*;
#(
  parameter int FW = 32,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] cur_freq,
  input  logic [HW-1:0] up_thr,
  input  logic [HW-1:0] dn_thr,
  output logic [FW+3:0] raw_hi_q,
  output logic [FW+3:0] raw_lo_q
);
  localparam int RW = FW + 4;
  localparam int MW = RW + HW;

  logic [MW-1:0] base;
  logic [RW-1:0] hi_n, lo_n;

  always_comb begin
    base = MW'(cur_freq) * MW'(PERIOD_MS);
    hi_n = RW'((base * MW'(up_thr)) / MW'(PCT));
    lo_n = RW'((base * MW'(dn_thr)) / MW'(PCT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_hi_q <= '0;
      raw_lo_q <= '0;
    end else if (load) begin
      raw_hi_q <= hi_n;
      raw_lo_q <= lo_n;
    end
  end
endmodule

// File: rtl/boost_governor.sv
module boost_governor
  import bgov_pkg::*;
#(
  parameter int NCH = 2,
  parameter int FW  = 32,
  parameter int CW  = 32,
  parameter int KW  = 16,
  parameter int HW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [NCH-1:0]           up_evt_i,
  input  logic [NCH-1:0]           dn_evt_i,
  input  logic [NCH-1:0][CW-1:0]   avg_cnt_i,
  input  logic [FW-1:0]            cur_freq_i,
  input  logic [FW-1:0]            max_freq_i,
  input  logic [FW-1:0]            floor_freq_i,
  input  logic [NCH-1:0][KW-1:0]   up_coeff_i,
  input  logic [NCH-1:0][KW-1:0]   dn_coeff_i,
  input  logic [NCH-1:0][HW-1:0]   up_thr_i,
  input  logic [NCH-1:0][HW-1:0]   dn_thr_i,
  input  logic [NCH-1:0][CW-1:0]   dep_thr_i,
  output logic [NCH-1:0][FW-1:0]   boost_o,
  output logic [NCH-1:0]           arm_above_o,
  output logic [NCH-1:0]           arm_below_o,
  output logic [NCH-1:0][CW:0]     avg_hi_o,
  output logic [NCH-1:0][CW-1:0]   avg_lo_o,
  output logic [NCH-1:0][FW+3:0]   raw_hi_o,
  output logic [NCH-1:0][FW+3:0]   raw_lo_o,
  output logic [CW+7:0]            target_o,
  output logic                     done_o
);
  localparam int TW = CW + 8;

  logic [1:0]              rst_pipe;
  logic                    rst_q;
  logic [FW-1:0]           cur_q;
  logic                    freq_chg;
  logic                    s1_q;
  logic [NCH-1:0][CW-1:0]  avg_q_w;
  logic [NCH-1:0][TW-1:0]  tgt_w;
  logic [TW-1:0]           tgt_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q    = rst_pipe[1];
  assign freq_chg = (cur_freq_i != cur_q);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    arm_t arm_w;

    bgov_boost_step #(.FW(FW), .CW(CW), .KW(KW)) u_step (
      .clk(clk), .rst_n(rst_q), .start(start_i),
      .up_evt(up_evt_i[g]), .dn_evt(dn_evt_i[g]), .avg_in(avg_cnt_i[g]),
      .max_freq(max_freq_i), .up_coeff(up_coeff_i[g]), .dn_coeff(dn_coeff_i[g]),
      .dep_thr(dep_thr_i[g]), .boost_q(boost_o[g]), .arm_q(arm_w),
      .avg_q(avg_q_w[g]), .avg_hi_q(avg_hi_o[g]), .avg_lo_q(avg_lo_o[g]));

    assign arm_above_o[g] = arm_w.above;
    assign arm_below_o[g] = arm_w.below;

    bgov_target #(.FW(FW), .CW(CW), .HW(HW), .TW(TW)) u_tgt (
      .avg(avg_q_w[g]), .boost(boost_o[g]), .up_thr(up_thr_i[g]),
      .dep_thr(dep_thr_i[g]), .floor_freq(floor_freq_i), .tgt(tgt_w[g]));

    bgov_raw_wmark #(.FW(FW), .HW(HW)) u_raw (
      .clk(clk), .rst_n(rst_q), .load(freq_chg), .cur_freq(cur_freq_i),
      .up_thr(up_thr_i[g]), .dn_thr(dn_thr_i[g]),
      .raw_hi_q(raw_hi_o[g]), .raw_lo_q(raw_lo_o[g]));
  end

  always_comb begin
    tgt_max = '0;
    for (int i = 0; i < NCH; i++)
      if (tgt_w[i] > tgt_max) tgt_max = tgt_w[i];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cur_q    <= '0;
      s1_q     <= 1'b0;
      done_o   <= 1'b0;
      target_o <= '0;
    end else begin
      if (freq_chg) cur_q <= cur_freq_i;
      s1_q   <= start_i;
      done_o <= s1_q;
      if (s1_q) target_o <= tgt_max;
    end
  end

  // R9
  done_lag_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |-> $past(start_i, 2));
  // R7
  raw_track_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $changed(cur_freq_i) |=> !$stable(cur_q) || cur_q == cur_freq_i);
endmodule

// File: tb/boost_governor_bench.sv
module boost_governor_bench;
  localparam int CLK_P = 10;
  localparam longint unsigned MAXF = 200000;
  localparam longint unsigned BAND = 14400;

  typedef struct packed {
    logic [1:0]  up;
    logic [1:0]  dn;
    logic [31:0] a0;
    logic [31:0] a1;
    logic [31:0] b0;
    logic [31:0] b1;
  } vec_t;

  localparam vec_t TAB [8] = '{
    '{2'b11, 2'b00, 32'd30000, 32'd60000, 32'd16000,  32'd16000},
    '{2'b11, 2'b00, 32'd45000, 32'd40000, 32'd48000,  32'd144000},
    '{2'b11, 2'b00, 32'd90000, 32'd70000, 32'd112000, 32'd200000},
    '{2'b00, 2'b11, 32'd20000, 32'd55000, 32'd56000,  32'd180000},
    '{2'b00, 2'b01, 32'd15000, 32'd30000, 32'd28000,  32'd180000},
    '{2'b00, 2'b11, 32'd12000, 32'd20000, 32'd14000,  32'd162000},
    '{2'b00, 2'b11, 32'd8000,  32'd45000, 32'd0,      32'd145800},
    '{2'b00, 2'b00, 32'd5000,  32'd52000, 32'd0,      32'd145800}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [1:0]        up_evt_i, dn_evt_i;
  logic [1:0][31:0]  avg_cnt_i;
  logic [31:0]       cur_freq_i, max_freq_i, floor_freq_i;
  logic [1:0][15:0]  up_coeff_i, dn_coeff_i;
  logic [1:0][7:0]   up_thr_i, dn_thr_i;
  logic [1:0][31:0]  dep_thr_i;
  logic [1:0][31:0]  boost_o;
  logic [1:0]        arm_above_o, arm_below_o;
  logic [1:0][32:0]  avg_hi_o;
  logic [1:0][31:0]  avg_lo_o;
  logic [1:0][35:0]  raw_hi_o, raw_lo_o;
  logic [39:0]       target_o;
  logic              done_o;

  int n_chk = 0;
  int n_bad = 0;
  logic ma [2];
  logic mbl [2];

  boost_governor u_boost_governor (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .up_evt_i(up_evt_i),
    .dn_evt_i(dn_evt_i), .avg_cnt_i(avg_cnt_i), .cur_freq_i(cur_freq_i),
    .max_freq_i(max_freq_i), .floor_freq_i(floor_freq_i),
    .up_coeff_i(up_coeff_i), .dn_coeff_i(dn_coeff_i), .up_thr_i(up_thr_i),
    .dn_thr_i(dn_thr_i), .dep_thr_i(dep_thr_i), .boost_o(boost_o),
    .arm_above_o(arm_above_o), .arm_below_o(arm_below_o),
    .avg_hi_o(avg_hi_o), .avg_lo_o(avg_lo_o), .raw_hi_o(raw_hi_o),
    .raw_lo_o(raw_lo_o), .target_o(target_o), .done_o(done_o));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint unsigned m_tgt(input longint unsigned a, input longint unsigned b,
      input longint unsigned thr, input longint unsigned dep, input longint unsigned fl);
    longint unsigned s;
    s = (a / 12) * (10000 / thr) / 100 + b;
    if (dep != 0 && a >= dep && fl > s) s = fl;
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 2; i++) begin ma[i] = 1'b1; mbl[i] = 1'b1; end
    repeat (2) @(negedge clk);
    // R1: state while reset is held
    for (int c = 0; c < 2; c++) begin
      chk(boost_o[c] == 0, "R1", "boost", boost_o[c], 0);
      chk(arm_above_o[c] && arm_below_o[c], "R1", "arms", {arm_above_o[c], arm_below_o[c]}, 3);
      chk(raw_hi_o[c] == 0 && avg_hi_o[c] == 0, "R1", "watermarks", raw_hi_o[c], 0);
    end
    chk(target_o == 0, "R1", "target", target_o, 0);
    chk(done_o == 0, "R1", "done", done_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic ev(input logic [1:0] u, input logic [1:0] d,
                    input longint unsigned a0, input longint unsigned a1,
                    input longint unsigned b0, input longint unsigned b1);
    longint unsigned a [2];
    longint unsigned b [2];
    longint unsigned t, tc;
    string req;
    a[0] = a0; a[1] = a1; b[0] = b0; b[1] = b1;
    @(negedge clk);
    up_evt_i = u; dn_evt_i = d;
    avg_cnt_i[0] = 32'(a0); avg_cnt_i[1] = 32'(a1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 2; c++) begin
      if (u[c] && d[c]) req = "R10";
      else if (u[c]) req = "R2";
      else if (d[c]) req = "R3";
      else req = "R4";
      if (u[c]) begin ma[c] = (b[c] != MAXF); mbl[c] = 1'b1; end
      else if (d[c]) begin ma[c] = 1'b1; mbl[c] = (b[c] != 0); end
      if (dep_thr_i[c] != 0) begin
        if (a[c] >= dep_thr_i[c]) mbl[c] = 1'b1;
        else if (b[c] == 0) mbl[c] = 1'b0;
      end
      chk(boost_o[c] == 32'(b[c]), req, "boost", boost_o[c], b[c]);
      chk(arm_above_o[c] == ma[c], req, "arm above", arm_above_o[c], ma[c]);
      chk(arm_below_o[c] == mbl[c], "R5", "arm below", arm_below_o[c], mbl[c]);
      chk(avg_hi_o[c] == 33'(a[c] + BAND), "R6", "avg hi", avg_hi_o[c], a[c] + BAND);
      chk(avg_lo_o[c] == 32'((a[c] >= BAND) ? a[c] - BAND : 0), "R6", "avg lo",
          avg_lo_o[c], (a[c] >= BAND) ? a[c] - BAND : 0);
    end
    chk(done_o == 1'b0, "R9", "done early", done_o, 0);
    @(negedge clk);
    t = 0;
    for (int c = 0; c < 2; c++) begin
      tc = m_tgt(a[c], b[c], up_thr_i[c], dep_thr_i[c], floor_freq_i);
      if (tc > t) t = tc;
    end
    chk(target_o == 40'(t), "R8", "target", target_o, t);
    chk(done_o == 1'b1, "R9", "done pulse", done_o, 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R9", "done width", done_o, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1; start_i = 1'b0; up_evt_i = '0; dn_evt_i = '0; avg_cnt_i = '0;
    cur_freq_i = 32'd100000; max_freq_i = 32'(MAXF); floor_freq_i = '0;
    up_coeff_i[0] = 16'd200; dn_coeff_i[0] = 16'd50; up_thr_i[0] = 8'd60; dn_thr_i[0] = 8'd40;
    dep_thr_i[0] = '0;
    up_coeff_i[1] = 16'd800; dn_coeff_i[1] = 16'd90; up_thr_i[1] = 8'd27; dn_thr_i[1] = 8'd10;
    dep_thr_i[1] = 32'd50000;
    do_reset();

    // R7: raw watermarks for 100000 kHz
    chk(raw_hi_o[0] == 36'd720000, "R7", "raw hi ch0", raw_hi_o[0], 720000);
    chk(raw_lo_o[0] == 36'd480000, "R7", "raw lo ch0", raw_lo_o[0], 480000);
    chk(raw_hi_o[1] == 36'd324000, "R7", "raw hi ch1", raw_hi_o[1], 324000);
    chk(raw_lo_o[1] == 36'd120000, "R7", "raw lo ch1", raw_lo_o[1], 120000);
    @(negedge clk);
    cur_freq_i = 32'd50000;
    @(negedge clk);
    chk(raw_hi_o[0] == 36'd360000, "R7", "raw hi after change", raw_hi_o[0], 360000);
    chk(raw_lo_o[1] == 36'd60000, "R7", "raw lo after change", raw_lo_o[1], 60000);

    // table walk: growth, clamp, decay, snap, idle
    for (int i = 0; i < 8; i++)
      ev(TAB[i].up, TAB[i].dn, TAB[i].a0, TAB[i].a1, TAB[i].b0, TAB[i].b1);

    // R3: decay landing exactly on 8000 is kept
    ev(2'b01, 2'b00, 20000, 52000, 16000, 145800);
    ev(2'b00, 2'b01, 20000, 52000, 8000, 145800);
    chk(arm_below_o[0] == 1'b1, "R3", "below kept at 8000", arm_below_o[0], 1);
    ev(2'b00, 2'b01, 20000, 52000, 0, 145800);
    // R10: both flags, growth wins
    ev(2'b01, 2'b01, 20000, 52000, 16000, 145800);

    // R5 and R8: dependency threshold and floor on a fresh channel state
    do_reset();
    floor_freq_i = 32'd150000;
    ev(2'b00, 2'b00, 1000, 10000, 0, 0);
    chk(arm_below_o[1] == 1'b0, "R5", "below cleared", arm_below_o[1], 0);
    ev(2'b00, 2'b00, 1000, 60000, 0, 0);
    chk(arm_below_o[1] == 1'b1, "R5", "below forced", arm_below_o[1], 1);
    chk(target_o == 40'd150000, "R8", "floor applied", target_o, 150000);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule